// File: doc/BRIEF.md
# Timestamp Capture and Event Interrupt Unit

This unit latches the running 64-bit time value whenever one of two external trigger pins shows a rising edge. It also gathers those captures and a once-per-second pulse from the time counter into a small set of maskable event flags that drive a single interrupt line. The unit does not keep time itself. A separate counter supplies the current time on `time_i`, and the unit samples it.

The trigger pins may be asynchronous. Each passes through a two-stage synchroniser and then an edge detector. Every channel presents its captured time as a pair of 32-bit words: software reads the lower word first and the upper word second. In queued mode (`FIFO_MODE=1`), each channel keeps up to `FIFO_DEPTH` captures in arrival order. A status bit stays high while any capture is waiting, and reading the upper word retires the oldest entry. In single mode (`FIFO_MODE=0`), each channel has one holding register, and every new capture overwrites it.

Software enables a source in two steps: it clears any stale pending flag by writing a one to that event bit, and then it sets the matching mask bit. To disable a source it clears the mask bit only.

Top module: `ts_capture_unit`

Register word addresses on `addr_i` (3 bits):

| Address | Register |
|---|---|
| 0 | Event flags: bit 0 channel 0, bit 1 channel 1, bit 2 per-second pulse |
| 1 | Mask: same bit layout as the event flags |
| 2 | Status: bit 0 channel 0 valid, bit 1 channel 1 valid |
| 4 | Channel 0 lower word |
| 5 | Channel 0 upper word |
| 6 | Channel 1 lower word |
| 7 | Channel 1 upper word |
| 3 | Reads as zero |

## Requirements
- R1: After reset, the event flags, the mask and the status read zero, every timestamp word reads zero, and `irq_o` is low.
- R2: A trigger that rises is captured on the third rising clock edge after it goes high. The stored value is the `time_i` present just before that edge. Event bit 0 or 1 (for channel 0 or 1) is set on the same edge. A trigger held high produces exactly one capture.
- R3: Address 4 or 6 returns bits 31:0 of the channel's oldest stored time, and address 5 or 7 returns bits 63:32.
- R4: In queued mode, captures are returned in arrival order. Status bit 0 or 1 (for channel 0 or 1) is high while at least one entry is held. A read of the upper-word address removes the oldest entry.
- R5: In queued mode, a capture that arrives while `FIFO_DEPTH` entries are held (default 4) is discarded, but its event bit is still set.
- R6: In queued mode, both words of an empty channel read zero, and an upper-word read of an empty channel changes nothing.
- R7: In single mode, a new capture replaces the held value. The status bit is set by a capture and cleared by an upper-word read, and the held value stays readable after that read.
- R8: A write to address 0 clears exactly the event bits written as one and leaves the bits written as zero unchanged.
- R9: An event that occurs in the same cycle as a write that clears its bit leaves the bit set.
- R10: The mask register at address 1 reads back what was written. `irq_o` is high exactly when some event bit and its mask bit are both set.
- R11: `pps_i` sampled high on a clock edge sets event bit 2.
- R12: Clearing a mask bit lowers `irq_o` but leaves the event bit pending. Clearing a pending event and then setting its mask bit keeps `irq_o` low until a new event of that source arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_i | input | 64 | Current time from the time counter |
| trig_i | input | 2 | Asynchronous external trigger pins, one per channel |
| pps_i | input | 1 | Once-per-second pulse from the time counter |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (an upper-word read retires the entry) |
| addr_i | input | 3 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from `addr_i` |
| irq_o | output | 1 | Interrupt request |

## Verification
Captures are made with distinct 64-bit time values whose upper and lower halves differ. This separates a word swap, a stale entry and an off-by-one sampling cycle from a correct capture. The event flag is checked one edge before and one edge after the expected capture edge, which pins the synchroniser latency. Bursts of three and five captures separate in-order queueing from overwrite behaviour and expose the drop-on-full case. A second instance in single mode shows that it overwrites where the queued instance accumulates. Event writes with mixed one and zero bits, an event that collides with a clearing write, and mask toggling around a pending event separate selective clearing, set priority and the enable and disable sequences.

// File: rtl/ts_cap_pkg.sv
package ts_cap_pkg;
    localparam int DATA_W   = 32;
    localparam int TIME_W   = 2 * DATA_W;
    localparam int NUM_CH   = 2;
    localparam int N_EVT    = NUM_CH + 1;
    localparam int EVT_PPS  = NUM_CH;
    localparam int ADDR_W   = 3;

    localparam logic [ADDR_W-1:0] A_EVT  = 3'd0;
    localparam logic [ADDR_W-1:0] A_MASK = 3'd1;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd2;
    localparam logic [ADDR_W-1:0] A_LO0  = 3'd4;
    localparam logic [ADDR_W-1:0] A_HI0  = 3'd5;
    localparam logic [ADDR_W-1:0] A_LO1  = 3'd6;
    localparam logic [ADDR_W-1:0] A_HI1  = 3'd7;
endpackage

// File: rtl/ts_trig_sync.sv
module ts_trig_sync #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_i,
    output logic [N-1:0] rise_o
);
    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
        logic [N-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = pin_i;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = st_q.s2 & ~st_q.prev;
endmodule

// File: rtl/ts_cap_store.sv
module ts_cap_store #(
    parameter int FIFO_MODE = 1,
    parameter int DEPTH     = 4,
    parameter int TW        = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_i,
    input  logic [TW-1:0] time_i,
    input  logic          pop_i,
    output logic [TW-1:0] head_o,
    output logic          valid_o
);
    generate
        if (FIFO_MODE != 0) begin : g_fifo
            localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
            localparam int CNT_W = $clog2(DEPTH + 1);
            localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
            localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

            typedef struct packed {
                logic [DEPTH-1:0][TW-1:0] mem;
                logic [PTR_W-1:0]         wr;
                logic [PTR_W-1:0]         rd;
                logic [CNT_W-1:0]         cnt;
            } fifo_t;

            fifo_t f_d, f_q;
            logic  do_push, do_pop;

            always_comb begin
                f_d     = f_q;
                do_push = cap_i && (f_q.cnt != FULL);
                do_pop  = pop_i && (f_q.cnt != '0);
                if (do_push) begin
                    f_d.mem[f_q.wr] = time_i;
                    f_d.wr = (f_q.wr == LAST) ? '0 : f_q.wr + 1'b1;
                end
                if (do_pop) begin
                    f_d.rd = (f_q.rd == LAST) ? '0 : f_q.rd + 1'b1;
                end
                case ({do_push, do_pop})
                    2'b10:   f_d.cnt = f_q.cnt + 1'b1;
                    2'b01:   f_d.cnt = f_q.cnt - 1'b1;
                    default: f_d.cnt = f_q.cnt;
                endcase
            end

            always_ff @(posedge clk) begin
                if (!rst_n) f_q <= '0;
                else        f_q <= f_d;
            end

            assign valid_o = (f_q.cnt != '0);
            assign head_o  = valid_o ? f_q.mem[f_q.rd] : '0;
        end else begin : g_single
            typedef struct packed {
                logic [TW-1:0] ts;
                logic          vld;
            } hold_t;

            hold_t h_d, h_q;

            always_comb begin
                h_d = h_q;
                if (pop_i) h_d.vld = 1'b0;
                if (cap_i) begin
                    h_d.ts  = time_i;
                    h_d.vld = 1'b1;
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) h_q <= '0;
                else        h_q <= h_d;
            end

            assign valid_o = h_q.vld;
            assign head_o  = h_q.ts;
        end
    endgenerate
endmodule

// File: rtl/ts_event_ctl.sv
module ts_event_ctl #(
    parameter int N_EVT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_EVT-1:0] set_i,
    input  logic             clr_we_i,
    input  logic             mask_we_i,
    input  logic [N_EVT-1:0] wdata_i,
    output logic [N_EVT-1:0] evt_o,
    output logic [N_EVT-1:0] mask_o,
    output logic             irq_o
);
    typedef struct packed {
        logic [N_EVT-1:0] evt;
        logic [N_EVT-1:0] mask;
    } ectl_t;

    ectl_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (clr_we_i)  r_d.evt  = r_q.evt & ~wdata_i;
        r_d.evt = r_d.evt | set_i;
        if (mask_we_i) r_d.mask = wdata_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign evt_o  = r_q.evt;
    assign mask_o = r_q.mask;
    assign irq_o  = |(r_q.evt & r_q.mask);
endmodule

// File: rtl/ts_capture_unit.sv
module ts_capture_unit
    import ts_cap_pkg::*;
#(
    parameter int FIFO_MODE  = 1,
    parameter int FIFO_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [63:0]       time_i,
    input  logic [1:0]        trig_i,
    input  logic              pps_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [2:0]        addr_i,
    input  logic [31:0]       wdata_i,
    output logic [31:0]       rdata_o,
    output logic              irq_o
);
    logic [NUM_CH-1:0]             rise_w;
    logic [NUM_CH-1:0]             valid_w;
    logic [NUM_CH-1:0][TIME_W-1:0] head_w;
    logic [N_EVT-1:0]              evt_w;
    logic [N_EVT-1:0]              mask_w;

    ts_trig_sync #(.N(NUM_CH)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (trig_i),
        .rise_o (rise_w)
    );

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            localparam logic [ADDR_W-1:0] HI_ADDR = A_HI0 + ADDR_W'(2 * c);
            logic pop_w;
            assign pop_w = rd_en_i && (addr_i == HI_ADDR);

            ts_cap_store #(
                .FIFO_MODE (FIFO_MODE),
                .DEPTH     (FIFO_DEPTH),
                .TW        (TIME_W)
            ) u_store (
                .clk     (clk),
                .rst_n   (rst_n),
                .cap_i   (rise_w[c]),
                .time_i  (time_i),
                .pop_i   (pop_w),
                .head_o  (head_w[c]),
                .valid_o (valid_w[c])
            );
        end
    endgenerate

    ts_event_ctl #(.N_EVT(N_EVT)) u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     ({pps_i, rise_w}),
        .clr_we_i  (wr_en_i && (addr_i == A_EVT)),
        .mask_we_i (wr_en_i && (addr_i == A_MASK)),
        .wdata_i   (wdata_i[N_EVT-1:0]),
        .evt_o     (evt_w),
        .mask_o    (mask_w),
        .irq_o     (irq_o)
    );

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            A_EVT:   rdata_o[N_EVT-1:0]  = evt_w;
            A_MASK:  rdata_o[N_EVT-1:0]  = mask_w;
            A_STAT:  rdata_o[NUM_CH-1:0] = valid_w;
            A_LO0:   rdata_o = head_w[0][DATA_W-1:0];
            A_HI0:   rdata_o = head_w[0][TIME_W-1:DATA_W];
            A_LO1:   rdata_o = head_w[1][DATA_W-1:0];
            A_HI1:   rdata_o = head_w[1][TIME_W-1:DATA_W];
            default: rdata_o = '0;
        endcase
    end
endmodule

module ts_capture_unit_chk
    import ts_cap_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en_i,
    input logic             rd_en_i,
    input logic [2:0]       addr_i,
    input logic [31:0]      wdata_i,
    input logic             irq_o,
    input logic [1:0]       rise_w,
    input logic [1:0]       valid_w,
    input logic [N_EVT-1:0] evt_w,
    input logic [N_EVT-1:0] mask_w
);
    // R2
    capture_sets_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_w[0] |=> evt_w[0]);

    // R8
    w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == A_EVT && wdata_i[1] && !rise_w[1]) |=> !evt_w[1]);

    // R4
    valid_fall_on_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(valid_w[0]) |-> $past(rd_en_i && addr_i == A_HI0));

    // R4
    valid_fall_on_pop1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(valid_w[1]) |-> $past(rd_en_i && addr_i == A_HI1));

    // R10
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_w == '0) |-> !irq_o);

    // R10
    mask_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && addr_i == A_MASK) |=> $stable(mask_w));
endmodule

bind ts_capture_unit ts_capture_unit_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en_i (wr_en_i),
    .rd_en_i (rd_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .irq_o   (irq_o),
    .rise_w  (rise_w),
    .valid_w (valid_w),
    .evt_w   (evt_w),
    .mask_w  (mask_w)
);

// File: tb/ts_capture_unit_bench.sv
module ts_capture_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] time_i = '0;
    logic [1:0]  trig_f = '0;
    logic [1:0]  trig_s = '0;
    logic        pps_i = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rd_f, rd_s;
    logic        irq_f, irq_s;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ts_capture_unit #(.FIFO_MODE(1), .FIFO_DEPTH(4)) u_ts_capture_unit (
        .clk(clk), .rst_n(rst_n), .time_i(time_i), .trig_i(trig_f), .pps_i(pps_i),
        .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rd_f), .irq_o(irq_f)
    );

    ts_capture_unit #(.FIFO_MODE(0), .FIFO_DEPTH(4)) u_ts_capture_unit_single (
        .clk(clk), .rst_n(rst_n), .time_i(time_i), .trig_i(trig_s), .pps_i(pps_i),
        .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rd_s), .irq_o(irq_s)
    );

    task automatic check(input string what, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", what, got, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] qf, output logic [31:0] qs);
        addr = a; rd_en = 1'b1;
        #1; qf = rd_f; qs = rd_s;
        @(posedge clk); @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic read_f(input logic [2:0] a, output logic [31:0] q);
        logic [31:0] dummy;
        bus_read(a, q, dummy);
    endtask

    task automatic pulse(input bit single, input int ch, input logic [63:0] t);
        time_i = t;
        if (single) trig_s[ch] = 1'b1; else trig_f[ch] = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        if (single) trig_s[ch] = 1'b0; else trig_f[ch] = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [31:0] q;
        read_f(3'd0, q); check("R1 event after reset", q, 0);
        read_f(3'd1, q); check("R1 mask after reset", q, 0);
        read_f(3'd2, q); check("R1 status after reset", q, 0);
        read_f(3'd4, q); check("R1 ch0 lower after reset", q, 0);
        check("R1 irq after reset", irq_f, 0);
    endtask

    task automatic t_latency;
        logic [31:0] q;
        time_i = 64'h1111_2222_3333_4444;
        trig_f[0] = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        read_f(3'd0, q); check("R2 no event after two edges", q, 0);
        read_f(3'd0, q); check("R2 event on third edge", q, 1);
        time_i = 64'h9999_9999_9999_9999;
        repeat (5) @(negedge clk);
        trig_f[0] = 1'b0;
        repeat (3) @(negedge clk);
        read_f(3'd2, q); check("R4 status valid after capture", q, 1);
        read_f(3'd4, q); check("R3 lower word", q, 32'h3333_4444);
        read_f(3'd5, q); check("R3 upper word", q, 32'h1111_2222);
        read_f(3'd2, q); check("R2 held level gives one capture", q, 0);
        bus_write(3'd0, 32'h7);
    endtask

    task automatic t_order;
        logic [31:0] q;
        pulse(0, 1, 64'hA000_0001_B000_0001);
        pulse(0, 1, 64'hA000_0002_B000_0002);
        pulse(0, 1, 64'hA000_0003_B000_0003);
        read_f(3'd2, q); check("R4 status bit1 set", q, 2);
        for (int i = 1; i <= 3; i++) begin
            read_f(3'd6, q); check("R4 order lower", q, 32'hB000_0000 + i);
            read_f(3'd7, q); check("R4 order upper", q, 32'hA000_0000 + i);
        end
        read_f(3'd2, q); check("R4 status clear after drain", q, 0);
    endtask

    task automatic t_full;
        logic [31:0] q;
        bus_write(3'd0, 32'h7);
        for (int i = 0; i < 5; i++) pulse(0, 0, {32'hC0, 32'(16 + i)});
        read_f(3'd0, q); check("R5 event set after dropped capture", q, 1);
        for (int i = 0; i < 4; i++) begin
            read_f(3'd4, q); check("R5 kept entry lower", q, 32'(16 + i));
            read_f(3'd5, q); check("R5 kept entry upper", q, 32'hC0);
        end
        read_f(3'd2, q); check("R5 fifth capture dropped", q, 0);
    endtask

    task automatic t_empty;
        logic [31:0] q;
        read_f(3'd6, q); check("R6 empty lower reads zero", q, 0);
        read_f(3'd7, q); check("R6 empty upper reads zero", q, 0);
        pulse(0, 1, 64'h0000_0055_0000_0066);
        read_f(3'd6, q); check("R6 capture after empty pop", q, 32'h66);
        read_f(3'd7, q); check("R6 capture after empty pop upper", q, 32'h55);
        read_f(3'd2, q); check("R6 status after single pop", q, 0);
    endtask

    task automatic t_w1c;
        logic [31:0] q;
        read_f(3'd0, q); check("R8 precondition both channel bits", q, 3);
        bus_write(3'd0, 32'h1);
        read_f(3'd0, q); check("R8 only written bit cleared", q, 2);
        bus_write(3'd0, 32'h2);
        read_f(3'd0, q); check("R8 second bit cleared", q, 0);
    endtask

    task automatic t_pps;
        logic [31:0] q;
        pps_i = 1'b1; @(negedge clk); pps_i = 1'b0;
        read_f(3'd0, q); check("R11 pulse sets bit 2", q, 4);
    endtask

    task automatic t_mask;
        logic [31:0] q;
        check("R10 irq low while unmasked-off", irq_f, 0);
        bus_write(3'd1, 32'h4);
        read_f(3'd1, q); check("R10 mask readback", q, 4);
        check("R10 irq high with pending and mask", irq_f, 1);
        bus_write(3'd1, 32'h0);
        check("R12 disable lowers irq", irq_f, 0);
        read_f(3'd0, q); check("R12 event still pending after disable", q, 4);
        bus_write(3'd0, 32'h4);
        bus_write(3'd1, 32'h4);
        check("R12 enable sequence keeps irq low", irq_f, 0);
        pps_i = 1'b1; @(negedge clk); pps_i = 1'b0;
        check("R12 new event raises irq", irq_f, 1);
        bus_write(3'd1, 32'h0);
        bus_write(3'd0, 32'h7);
    endtask

    task automatic t_collide;
        logic [31:0] q;
        pulse(0, 0, 64'h1);
        read_f(3'd0, q); check("R9 precondition", q, 1);
        time_i = 64'h2;
        trig_f[0] = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        bus_write(3'd0, 32'h1);
        read_f(3'd0, q); check("R9 set wins over clear", q, 1);
        trig_f[0] = 1'b0;
        repeat (3) @(negedge clk);
        read_f(3'd5, q); read_f(3'd5, q);
        bus_write(3'd0, 32'h7);
    endtask

    task automatic t_single;
        logic [31:0] qf, qs;
        pulse(1, 0, 64'h0000_00D1_0000_00E1);
        pulse(1, 0, 64'h0000_00D2_0000_00E2);
        bus_read(3'd2, qf, qs); check("R7 single status set", qs, 1);
        bus_read(3'd4, qf, qs); check("R7 newest lower kept", qs, 32'hE2);
        bus_read(3'd5, qf, qs); check("R7 newest upper kept", qs, 32'hD2);
        bus_read(3'd2, qf, qs); check("R7 status cleared by upper read", qs, 0);
        bus_read(3'd4, qf, qs); check("R7 value stays readable", qs, 32'hE2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latency();
        t_order();
        t_full();
        t_empty();
        t_w1c();
        t_pps();
        t_mask();
        t_collide();
        t_single();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule